// File: doc/BRIEF.md
# Peripheral Event Router

The event router carries single-cycle strobes from peripheral event sources to the trigger inputs of other peripherals, with no processor in the path. The sources include timer overflow and compare match, comparator toggle, pin change, ADC conversion done, ADC window compare and real-time counter overflow. The sinks include ADC or DAC conversion start, input capture, timer count or clock, DMA request and pin output change. Eight routing channels run side by side. Each channel picks one numbered source line. Each sink picks one channel to listen to, and several sinks may listen to the same channel.

Software programs the routing through a small write/read register port. A sticky lock bit can freeze the routing for the rest of the run, or it can stay clear so the routing can be changed while the system runs. A source strobe crosses one register stage in its channel. A second, optional register stage in each sink, chosen by `OUT_REG`, keeps the source-to-sink delay at no more than two clocks.

Top module: `evr_router`

## Requirements
- R1: After reset every channel select, sink select and the lock bit read as 0, and no sink strobe is driven.
- R2: A channel select value k from 1 to NUM_SRC routes source line k, which is input bit k-1, into the channel. A value of 0 turns the channel off, so the channel never produces an event.
- R3: A sink select holds an enable in bit 3 and a channel index in bits 2:0. When the enable is 0, the sink never strobes.
- R4: A source strobe sampled at clock edge t produces a one-cycle strobe on every sink routed to it after edge t+OUT_REG. That delay is 1 clock with OUT_REG=0 and 2 clocks with OUT_REG=1. Strobes on consecutive cycles stay separate strobes on consecutive cycles.
- R5: All eight channels carry events in the same cycle without interfering, and one channel may drive several sinks at once.
- R6: The register map is as follows. Addresses 0-7 are the channel selects. Addresses 8-15 are the sink selects. Address 16 is the lock bit, in bit 0. Every mapped register reads back what was written into its low bits. Unmapped addresses read 0, and writes to them change nothing.
- R7: Writing 1 to lock bit 0 sets the lock. Once set, the lock stays set until reset, and writing 0 does not clear it.
- R8: While the lock is set, writes to channel and sink selects are ignored, and the existing routing keeps carrying events.
- R9: While the lock is clear, a new select value applies to strobes sampled after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (5) | Register address for both read and write |
| cfg_wdata | input | DATA_W (4) | Write data |
| cfg_rdata | output | DATA_W (4) | Combinational read data for cfg_addr |
| src_evt | input | NUM_SRC (15) | Source strobes; bit k-1 is source number k |
| act_evt | output | NUM_SINK (8) | Action strobes, one per sink |

## Verification
The assertions assume that source strobes and register writes are synchronous to `clk` and stable around its rising edge. They also assume that a select value above NUM_SRC is simply treated as an unmatched source. The bench changes every input only on the falling edge. It holds each write for exactly one rising edge and reads the combinational read port after it has settled. It looks at the sink strobes once per falling edge over a window that covers the whole allowed delay. This means an early, late or repeated strobe is seen as a mismatch.

// File: rtl/evr_pkg.sv
package evr_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CHAN = 2'd1,
    REG_SINK = 2'd2,
    REG_LOCK = 2'd3
  } reg_kind_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Address decode: channel selects, then sink selects, then the lock bit.
  function automatic reg_kind_e reg_kind(input int addr, input int nch, input int nsink);
    if (addr < nch) return REG_CHAN;
    if (addr < nch + nsink) return REG_SINK;
    if (addr == nch + nsink) return REG_LOCK;
    return REG_NONE;
  endfunction

endpackage

// File: rtl/evr_cfg_regs.sv
module evr_cfg_regs
  import evr_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_SINK = 8,
  parameter int SRC_W    = 4,
  parameter int SNK_W    = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [ADDR_W-1:0]                cfg_addr,
  input  logic [DATA_W-1:0]                cfg_wdata,
  output logic [DATA_W-1:0]                cfg_rdata,
  output logic [NUM_CH-1:0][SRC_W-1:0]     chan_sel,
  output logic [NUM_SINK-1:0][SNK_W-1:0]   sink_sel,
  output logic                             locked
);

  reg_kind_e                 kind;
  logic [NUM_CH-1:0]         wr_chan;
  logic [NUM_SINK-1:0]       wr_sink;
  logic                      wr_lock;
  logic [NUM_CH-1:0][SRC_W-1:0]   chan_q;
  logic [NUM_SINK-1:0][SNK_W-1:0] sink_q;
  logic                      lock_q;

  assign kind = reg_kind(int'(cfg_addr), NUM_CH, NUM_SINK);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      wr_chan[i] = cfg_we && !lock_q && (kind == REG_CHAN) && (int'(cfg_addr) == i);
    for (int j = 0; j < NUM_SINK; j++)
      wr_sink[j] = cfg_we && !lock_q && (kind == REG_SINK) && (int'(cfg_addr) == NUM_CH + j);
    wr_lock = cfg_we && (kind == REG_LOCK) && cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      sink_q <= '0;
      lock_q <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (wr_chan[i]) chan_q[i] <= cfg_wdata[SRC_W-1:0];
      for (int j = 0; j < NUM_SINK; j++)
        if (wr_sink[j]) sink_q[j] <= cfg_wdata[SNK_W-1:0];
      if (wr_lock) lock_q <= 1'b1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (int'(cfg_addr) == i) cfg_rdata[SRC_W-1:0] = chan_q[i];
    for (int j = 0; j < NUM_SINK; j++)
      if (int'(cfg_addr) == NUM_CH + j) cfg_rdata[SNK_W-1:0] = sink_q[j];
    if (kind == REG_LOCK) cfg_rdata[0] = lock_q;
  end

  assign chan_sel = chan_q;
  assign sink_sel = sink_q;
  assign locked   = lock_q;

  // R7: once set, the lock survives until reset
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R8: routing registers frozen while locked
  p_lock_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(chan_q) && $stable(sink_q)));

  // R6: a single write touches at most one routing register
  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_chan, wr_sink, wr_lock}));

endmodule

// File: rtl/evr_channel.sv
module evr_channel #(
  parameter int NUM_SRC = 15,
  parameter int SRC_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_W-1:0]   sel,
  input  logic [NUM_SRC-1:0] src_evt,
  output logic               pulse
);

  logic hit;
  logic pulse_q;

  always_comb begin
    hit = 1'b0;
    for (int k = 1; k <= NUM_SRC; k++)
      if (sel == SRC_W'(k)) hit = src_evt[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= hit;
  end

  assign pulse = pulse_q;

  // R2: a channel switched off stays silent
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> !pulse);

  // R4: a strobe on the selected line appears one edge later
  p_strobe_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel != '0) && (int'(sel) <= NUM_SRC) && src_evt[int'(sel) - 1]) |=> pulse);

  // R2: no strobe when selected line is quiet
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == '0) || (int'(sel) > NUM_SRC) || !src_evt[int'(sel) - 1]) |=> !pulse);

endmodule

// File: rtl/evr_sink.sv
module evr_sink #(
  parameter int NUM_CH  = 8,
  parameter int CH_W    = 3,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W:0]     sel,
  input  logic [NUM_CH-1:0] ch_pulse,
  output logic              act
);

  logic en;
  logic pick;

  assign en = sel[CH_W];

  always_comb begin
    pick = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (en && (sel[CH_W-1:0] == CH_W'(c))) pick = ch_pulse[c];
  end

  generate
    if (OUT_REG) begin : g_reg
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= pick;
      end
      assign act = act_q;

      // R4: registered sink follows its channel one edge later
      p_sink_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ch_pulse[sel[CH_W-1:0]]) |=> act);

      // R3: a disabled sink never strobes
      p_sink_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !act);
    end else begin : g_comb
      assign act = pick;

      // R3: a disabled sink never strobes
      p_sink_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !act);
    end
  endgenerate

endmodule

// File: rtl/evr_router.sv
module evr_router
  import evr_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_SRC  = 15,
  parameter int NUM_SINK = 8,
  parameter bit OUT_REG  = 1'b1,
  parameter int ADDR_W   = $clog2(NUM_CH + NUM_SINK + 1),
  parameter int DATA_W   = max2($clog2(NUM_SRC + 1), max2($clog2(NUM_CH), 1) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic [NUM_SRC-1:0]  src_evt,
  output logic [NUM_SINK-1:0] act_evt
);

  localparam int SRC_W = $clog2(NUM_SRC + 1);
  localparam int CH_W  = max2($clog2(NUM_CH), 1);
  localparam int SNK_W = CH_W + 1;

  logic [NUM_CH-1:0][SRC_W-1:0]   chan_sel;
  logic [NUM_SINK-1:0][SNK_W-1:0] sink_sel;
  logic                           locked;
  logic [NUM_CH-1:0]              ch_pulse;

  evr_cfg_regs #(
    .NUM_CH(NUM_CH), .NUM_SINK(NUM_SINK), .SRC_W(SRC_W), .SNK_W(SNK_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .chan_sel(chan_sel), .sink_sel(sink_sel), .locked(locked)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      evr_channel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_ch (
        .clk(clk), .rst_n(rst_n), .sel(chan_sel[c]),
        .src_evt(src_evt), .pulse(ch_pulse[c])
      );
    end
    for (genvar s = 0; s < NUM_SINK; s++) begin : g_sink
      evr_sink #(.NUM_CH(NUM_CH), .CH_W(CH_W), .OUT_REG(OUT_REG)) i_sink (
        .clk(clk), .rst_n(rst_n), .sel(sink_sel[s]),
        .ch_pulse(ch_pulse), .act(act_evt[s])
      );
    end
  endgenerate

  // R8: routing keeps working while locked: a locked system has no writes land
  p_locked_writes_void_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cfg_we && (int'(cfg_addr) < NUM_CH + NUM_SINK)) |=> $stable(chan_sel));

  // R1: lock starts clear after reset
  p_reset_unlocked_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !locked);

endmodule

// File: tb/test_evr_router.sv
`timescale 1ns/100ps
module test_evr_router;

  localparam int  NUM_CH   = 8;
  localparam int  NUM_SRC  = 15;
  localparam int  NUM_SINK = 8;
  localparam bit  OUT_REG  = 1'b1;
  localparam int  LAT      = 1 + int'(OUT_REG);
  localparam int  LOCK_A   = NUM_CH + NUM_SINK;

  // vector: {src_sel[3:0], chan[2:0], sink[2:0], fire_src[3:0], expect}
  localparam int NV = 8;
  localparam logic [14:0] VEC [NV] = '{
    {4'd1,  3'd0, 3'd0, 4'd1,  1'b1},
    {4'd5,  3'd3, 3'd6, 4'd5,  1'b1},
    {4'd15, 3'd7, 3'd7, 4'd15, 1'b1},
    {4'd4,  3'd2, 3'd1, 4'd3,  1'b0},
    {4'd0,  3'd5, 3'd4, 4'd1,  1'b0},
    {4'd9,  3'd6, 3'd3, 4'd9,  1'b1},
    {4'd2,  3'd1, 3'd5, 4'd2,  1'b1},
    {4'd7,  3'd4, 3'd2, 4'd0,  1'b0}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cfg_we = 1'b0;
  logic [4:0]          cfg_addr = '0;
  logic [3:0]          cfg_wdata = '0;
  logic [3:0]          cfg_rdata;
  logic [NUM_SRC-1:0]  src_evt = '0;
  logic [NUM_SINK-1:0] act_evt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  evr_router #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .NUM_SINK(NUM_SINK), .OUT_REG(OUT_REG))
  i_evr_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_evt(src_evt), .act_evt(act_evt)
  );

  task automatic chk(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = 4'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    cfg_addr = 5'(addr);
    #1;
    data = int'(cfg_rdata);
  endtask

  // Drive a source mask for `len` cycles, then check sinks over the full window.
  task automatic fire(input string req, input int mask, input int len, input int exp_mask);
    @(negedge clk);
    src_evt = NUM_SRC'(mask);
    for (int k = 1; k <= len + LAT + 1; k++) begin
      @(negedge clk);
      if (k == len) src_evt = '0;
      chk(req, $sformatf("act_evt at cycle %0d", k), int'(act_evt),
          ((k - LAT + 1 >= 1) && (k - LAT + 1 <= len)) ? exp_mask : 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a <= LOCK_A; a++) begin
      rd(a, v);
      chk("R1", $sformatf("reg %0d after reset", a), v, 0);
    end
    chk("R1", "act_evt after reset", int'(act_evt), 0);

    // R2 R3 R4: vector table
    for (int n = 0; n < NV; n++) begin
      logic [14:0] e;
      int sel, ch, sk, fs;
      e  = VEC[n];
      sel = int'(e[14:11]); ch = int'(e[10:8]); sk = int'(e[7:5]); fs = int'(e[4:1]);
      wr(ch, sel);
      wr(NUM_CH + sk, 8 + ch);
      rd(ch, v);
      chk("R6", "channel select readback", v, sel);
      rd(NUM_CH + sk, v);
      chk("R6", "sink select readback", v, 8 + ch);
      fire(e[0] ? "R4" : "R2", (fs == 0) ? 0 : (1 << (fs - 1)), 1, e[0] ? (1 << sk) : 0);
      wr(NUM_CH + sk, 0);
    end

    // R3: disabled sink with an active channel (ch0 still on source 1)
    wr(NUM_CH + 0, 0);
    fire("R3", 1, 1, 0);

    // R4: back-to-back strobes stay separate on consecutive cycles
    wr(0, 1);
    wr(NUM_CH + 0, 8 + 0);
    fire("R4", 1, 3, 1);
    wr(NUM_CH + 0, 0);

    // R5: all channels in parallel; sink j listens to channel 7-j
    for (int c = 0; c < NUM_CH; c++) wr(c, c + 1);
    for (int j = 0; j < NUM_SINK; j++) wr(NUM_CH + j, 8 + (7 - j));
    fire("R5", 8'hFF, 1, 8'hFF);
    fire("R5", 1 << 2, 1, 1 << 5);
    // fan-out: sinks 0 and 5 both on channel 2
    wr(NUM_CH + 0, 8 + 2);
    fire("R5", 1 << 2, 1, (1 << 5) | 1);
    wr(NUM_CH + 0, 8 + 7);

    // R9: run-time reconfiguration of channel 2 to source 10
    wr(2, 10);
    fire("R9", 1 << 2, 1, 0);
    fire("R9", 1 << 9, 1, 1 << 5);

    // R7 R8: lock
    wr(LOCK_A, 1);
    rd(LOCK_A, v);
    chk("R7", "lock readback", v, 1);
    wr(2, 1);
    rd(2, v);
    chk("R8", "channel select while locked", v, 10);
    wr(NUM_CH + 5, 0);
    rd(NUM_CH + 5, v);
    chk("R8", "sink select while locked", v, 8 + 2);
    fire("R8", 1 << 9, 1, 1 << 5);
    fire("R8", 1, 1, 1 << 7);
    wr(LOCK_A, 0);
    rd(LOCK_A, v);
    chk("R7", "lock after writing 0", v, 1);

    // R1 R7: reset clears lock and routing
    do_reset();
    rd(LOCK_A, v);
    chk("R7", "lock after reset", v, 0);
    rd(2, v);
    chk("R1", "channel 2 after reset", v, 0);
    fire("R1", 16'h7FFF, 1, 0);

    // R6: unmapped addresses read 0 and writes there change nothing
    for (int a = LOCK_A + 1; a < 32; a++) wr(a, 15);
    for (int a = LOCK_A + 1; a < 32; a += 5) begin
      rd(a, v);
      chk("R6", $sformatf("unmapped reg %0d", a), v, 0);
    end
    for (int a = 0; a <= LOCK_A; a++) begin
      rd(a, v);
      chk("R6", $sformatf("reg %0d after unmapped writes", a), v, 0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule